// File: doc/BRIEF.md
# Accumulator Processor with Return Stack

This block is a small 16-bit processor built around one accumulator. It steps through a program held in a single word-addressed memory. Each step fetches an instruction word, decodes it and executes it. Every operand is reached by direct addressing. The architectural state is:

- a program counter;
- the accumulator;
- one negative flag;
- a private return-address stack with its own pointer.

Subroutine entry and exit save and restore program counter values on this stack. The stack sits inside the block and never touches the data memory.

The block drives a synchronous memory port. The address is presented in one cycle and the read word arrives on `mem_rdata` in the next cycle. A write takes effect at the clock edge on which `mem_we` is high. After reset the processor starts fetching from `start_addr`. It keeps running until it executes a stop instruction. It then raises `halted`, freezes its state and issues no further memory traffic.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held and after it is released, the program counter takes the value of `start_addr` and the accumulator and flag are zero. During reset `mem_addr` equals `start_addr`, `mem_we` is low and `halted` is low.
- R2: An instruction word carries its operation in bits [15:13] and a 13-bit direct address in bits [12:0]. The full 13-bit field appears on `mem_addr` for memory-operand instructions.
- R3: Load (operation 100) copies the word at the addressed location into the accumulator.
- R4: Add (operation 010) adds the word at the addressed location to the accumulator, modulo 2^16.
- R5: Store (operation 101) writes the accumulator to the addressed location. `mem_we` is high for exactly one cycle per Store.
- R6: Branch-on-negative (operation 011) jumps to its address field when the negative flag is set. Otherwise it continues at the next word.
- R7: Call (operation 000) saves the address of the next word on the return stack and then jumps to its address field. Calls nest correctly to a depth of 16.
- R8: Return (operation 001, address field zero) resumes at the most recently saved address. Saved addresses are consumed in last-in, first-out order.
- R9: The negative flag changes only on Load and Add. It becomes bit 15 of the new accumulator value. Store, Call, Return and branches leave it unchanged.
- R10: Stop (operation 110) raises `halted` on the clock edge after its decode cycle. `halted` then stays high, `mem_we` stays low and `mem_addr` holds steady.
- R11: Operation 111 is treated as Stop.
- R12: Load and Add take three cycles each (fetch, decode, operand read). Every other instruction takes two cycles (fetch, decode).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_addr | input | 13 | Program counter value loaded by reset |
| mem_addr | output | 13 | Memory word address |
| mem_wdata | output | 16 | Data to be written (the accumulator) |
| mem_we | output | 1 | Write strobe for the current address |
| mem_rdata | input | 16 | Word read from the address of the previous cycle |
| halted | output | 1 | High once a stop instruction has executed |

## Verification
The accumulator and flag are not visible at the ports. A wrong accumulator value therefore shows up only at the next Store, as bad `mem_wdata`. A wrong flag shows up only at the next branch-on-negative, as a fetch from the wrong address two cycles later. A corrupted return stack slot or pointer stays hidden until the matching Return. That can be many instructions later, so the programs nest calls to full depth and log the accumulator on every return. Timing errors in the sequencer change the cycle count from reset release to `halted`, which is checked against the sum of the per-instruction costs.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int OPC_W = 3;

   typedef enum logic [OPC_W-1:0] {
      OP_CALL  = 3'b000,
      OP_RET   = 3'b001,
      OP_ADD   = 3'b010,
      OP_BRN   = 3'b011,
      OP_LOAD  = 3'b100,
      OP_STORE = 3'b101,
      OP_STOP  = 3'b110,
      OP_SPARE = 3'b111
   } opcode_e;

   typedef enum logic [1:0] {
      PH_FETCH  = 2'd0,
      PH_DECODE = 2'd1,
      PH_OPRD   = 2'd2,
      PH_HALT   = 2'd3
   } phase_e;

   typedef struct packed {
      logic call;
      logic ret;
      logic brn;
      logic rd;
      logic add;
      logic wr;
      logic stop;
   } ctl_t;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 13,
   parameter int SPARE_HALTS = 1
) (
   input  logic [DATA_W-1:0] instr,
   output ctl_t              ctl,
   output logic [ADDR_W-1:0] field
);

   localparam int OPC_LSB = DATA_W - OPC_W;

   generate
      if (OPC_LSB != ADDR_W) begin : g_bad_split
         $error("acc_cpu_decode: DATA_W must equal opcode width plus ADDR_W");
      end
   endgenerate

   opcode_e opc;
   logic    spare_stop;

   assign opc   = opcode_e'(instr[DATA_W-1:OPC_LSB]);
   assign field = instr[ADDR_W-1:0];

   generate
      if (SPARE_HALTS != 0) begin : g_spare_stop
         assign spare_stop = 1'b1;
      end else begin : g_spare_skip
         assign spare_stop = 1'b0;
      end
   endgenerate

   always_comb begin
      ctl = '0;
      unique case (opc)
         OP_CALL:  ctl.call = 1'b1;
         OP_RET:   ctl.ret  = 1'b1;
         OP_ADD:   begin ctl.rd = 1'b1; ctl.add = 1'b1; end
         OP_BRN:   ctl.brn  = 1'b1;
         OP_LOAD:  ctl.rd   = 1'b1;
         OP_STORE: ctl.wr   = 1'b1;
         OP_STOP:  ctl.stop = 1'b1;
         OP_SPARE: ctl.stop = spare_stop;
         default:  ctl.stop = 1'b1;
      endcase
   end

   // at most one memory action is ever requested per instruction (R2)
   always_comb begin
      assert ($countones({ctl.rd, ctl.wr, ctl.call, ctl.ret, ctl.brn, ctl.stop}) <= 1)
         else $error("p_one_action_r2: decoder requested more than one action");
   end

endmodule

// File: rtl/acc_cpu_rstack.sv
module acc_cpu_rstack #(
   parameter int WIDTH = 13,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] push_data,
   output logic [WIDTH-1:0] top_data
);

   localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || (1 << SP_W) != DEPTH) begin : g_bad_depth
         $error("acc_cpu_rstack: DEPTH must be a power of two, at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("acc_cpu_rstack: WIDTH must be positive");
      end
   endgenerate

   logic [SP_W-1:0]  sp;
   logic [SP_W-1:0]  sp_up;
   logic [WIDTH-1:0] slot [DEPTH];

   assign sp_up = sp + SP_W'(1);

   // pointer rests one below the first slot; push pre-increments
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp <= '1;
      end else if (push) begin
         sp <= sp_up;
      end else if (pop) begin
         sp <= sp - SP_W'(1);
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push && sp_up == SP_W'(i)) begin
            slot[i] <= push_data;
         end
      end
   end

   assign top_data = slot[sp];

   p_push_pop_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && pop));

   p_sp_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (sp == $past(sp) + SP_W'(1)));

   p_push_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (top_data == $past(push_data)));

   p_sp_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> (sp == $past(sp) - SP_W'(1)));

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
   parameter int DATA_W = 16
) (
   input  logic              is_add,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] operand,
   output logic [DATA_W-1:0] result,
   output logic              neg
);

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("acc_cpu_alu: DATA_W must be at least 2");
      end
   endgenerate

   assign result = is_add ? (acc_in + operand) : operand;
   assign neg    = result[DATA_W-1];

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int ADDR_W      = 13,
   parameter int DATA_W      = 16,
   parameter int STACK_DEPTH = 16,
   parameter int SPARE_HALTS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] start_addr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              halted
);

   generate
      if (DATA_W != OPC_W + ADDR_W) begin : g_bad_word
         $error("acc_cpu: DATA_W must equal opcode width plus ADDR_W");
      end
   endgenerate

   phase_e            phase;
   logic [ADDR_W-1:0] pc;
   logic [ADDR_W-1:0] pc_inc;
   logic [ADDR_W-1:0] pc_nxt;
   logic [DATA_W-1:0] acc;
   logic              nflag;
   logic              pend_add;

   ctl_t              ctl;
   logic [ADDR_W-1:0] field;
   logic              in_decode;
   logic              push;
   logic              pop;
   logic [ADDR_W-1:0] ret_addr;
   logic [DATA_W-1:0] alu_res;
   logic              alu_neg;

   acc_cpu_decode #(
      .DATA_W      (DATA_W),
      .ADDR_W      (ADDR_W),
      .SPARE_HALTS (SPARE_HALTS)
   ) u_dec (
      .instr (mem_rdata),
      .ctl   (ctl),
      .field (field)
   );

   acc_cpu_rstack #(
      .WIDTH (ADDR_W),
      .DEPTH (STACK_DEPTH)
   ) u_stk (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .pop       (pop),
      .push_data (pc_inc),
      .top_data  (ret_addr)
   );

   acc_cpu_alu #(
      .DATA_W (DATA_W)
   ) u_alu (
      .is_add  (pend_add),
      .acc_in  (acc),
      .operand (mem_rdata),
      .result  (alu_res),
      .neg     (alu_neg)
   );

   assign in_decode = (phase == PH_DECODE);
   assign pc_inc    = pc + ADDR_W'(1);
   assign push      = in_decode && ctl.call;
   assign pop       = in_decode && ctl.ret;

   always_comb begin
      if (ctl.call || (ctl.brn && nflag)) begin
         pc_nxt = field;
      end else if (ctl.ret) begin
         pc_nxt = ret_addr;
      end else if (ctl.stop || ctl.rd) begin
         pc_nxt = pc;
      end else begin
         pc_nxt = pc_inc;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_FETCH;
         pc       <= start_addr;
         acc      <= '0;
         nflag    <= 1'b0;
         pend_add <= 1'b0;
      end else begin
         unique case (phase)
            PH_FETCH: begin
               phase <= PH_DECODE;
            end
            PH_DECODE: begin
               pc       <= pc_nxt;
               pend_add <= ctl.add;
               if (ctl.stop) begin
                  phase <= PH_HALT;
               end else if (ctl.rd) begin
                  phase <= PH_OPRD;
               end else begin
                  phase <= PH_FETCH;
               end
            end
            PH_OPRD: begin
               acc   <= alu_res;
               nflag <= alu_neg;
               pc    <= pc_inc;
               phase <= PH_FETCH;
            end
            default: begin
               phase <= PH_HALT;
            end
         endcase
      end
   end

   assign mem_addr  = (in_decode && (ctl.rd || ctl.wr)) ? field : pc;
   assign mem_wdata = acc;
   assign mem_we    = in_decode && ctl.wr;
   assign halted    = (phase == PH_HALT);

   p_stop_enters_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_decode && ctl.stop) |=> halted);

   p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_we);

   p_halt_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(mem_addr));

   p_store_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   p_flag_only_alu_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_OPRD) |=> $stable(nflag));

   p_flag_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_OPRD) |=> (nflag == acc[DATA_W-1]));

   p_acc_only_alu_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_OPRD) |=> $stable(acc));

   p_oprd_after_decode_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_OPRD) |=> (phase == PH_FETCH));

endmodule

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;

   localparam int CLK_PERIOD = 10;
   localparam int AW  = 13;
   localparam int DW  = 16;
   localparam int MEMW = 1024;

   localparam logic [2:0] C_CALL  = 3'b000;
   localparam logic [2:0] C_RET   = 3'b001;
   localparam logic [2:0] C_ADD   = 3'b010;
   localparam logic [2:0] C_BRN   = 3'b011;
   localparam logic [2:0] C_LOAD  = 3'b100;
   localparam logic [2:0] C_STORE = 3'b101;
   localparam logic [2:0] C_STOP  = 3'b110;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_we;
   logic [DW-1:0] mem_rdata;
   logic          halted;

   logic [DW-1:0] mem [MEMW];
   int            wr_cnt = 0;
   logic [AW-1:0] last_wa = '0;
   logic [DW-1:0] last_wd = '0;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_cpu u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_addr (start_addr),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_we     (mem_we),
      .mem_rdata  (mem_rdata),
      .halted     (halted)
   );

   // synchronous memory, one-cycle read latency, low address bits only
   always @(posedge clk) begin
      if (mem_we) begin
         mem[mem_addr[9:0]] <= mem_wdata;
         wr_cnt  <= wr_cnt + 1;
         last_wa <= mem_addr;
         last_wd <= mem_wdata;
      end
      mem_rdata <= mem[mem_addr[9:0]];
   end

   function automatic logic [DW-1:0] ins(logic [2:0] op, int a);
      return {op, 13'(a)};
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < MEMW; i++) mem[i] = '0;
   endtask

   task automatic do_reset(logic [AW-1:0] s);
      @(negedge clk);
      rst_n = 1'b0;
      start_addr = s;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run(output int cyc);
      cyc = 0;
      while (!halted && cyc < 3000) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      clear_mem();
      mem[12'h155] = ins(C_STOP, 0);
      @(negedge clk);
      rst_n = 1'b0;
      start_addr = 13'h0155;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check(mem_addr == 13'h0155, "R1", "reset fetch address", int'(mem_addr), 'h155);
      check(mem_we == 1'b0, "R1", "reset write strobe", int'(mem_we), 0);
      check(halted == 1'b0, "R1", "reset halted", int'(halted), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_load_add_store();
      int cyc;
      int w0;
      logic [AW-1:0] a_hold;
      clear_mem();
      mem['h100] = ins(C_LOAD, 'h200);
      mem['h101] = ins(C_ADD, 'h201);
      mem['h102] = ins(C_STORE, 'h202);
      mem['h103] = ins(C_STOP, 0);
      mem['h200] = 16'd10;
      mem['h201] = 16'd20;
      do_reset(13'h0100);
      run(cyc);
      check(mem['h202] == 16'd30, "R3", "load then add stored sum", int'(mem['h202]), 30);
      check(cyc == 10, "R12", "cycles load/add/store/stop", cyc, 10);
      check(halted == 1'b1, "R10", "halted after stop", int'(halted), 1);
      w0 = wr_cnt;
      a_hold = mem_addr;
      repeat (20) @(negedge clk);
      check(wr_cnt == w0, "R10", "writes after halt", wr_cnt, w0);
      check(mem_addr == a_hold, "R10", "address after halt", int'(mem_addr), int'(a_hold));
      check(halted == 1'b1, "R10", "halted held", int'(halted), 1);
   endtask

   task automatic t_wrap_taken();
      int cyc;
      clear_mem();
      mem[0] = ins(C_LOAD, 'h100);
      mem[1] = ins(C_ADD, 'h101);
      mem[2] = ins(C_STORE, 'h102);
      mem[3] = ins(C_BRN, 6);
      mem[4] = ins(C_STOP, 0);
      mem[6] = ins(C_STORE, 'h103);
      mem[7] = ins(C_STOP, 0);
      mem['h100] = 16'h7FFF;
      mem['h101] = 16'h0001;
      mem['h103] = 16'h1111;
      do_reset('0);
      run(cyc);
      check(mem['h102] == 16'h8000, "R4", "add overflow wraps", int'(mem['h102]), 'h8000);
      // branch after a store still taken: store left the flag set
      check(mem['h103] == 16'h8000, "R6", "branch taken on negative", int'(mem['h103]), 'h8000);
      check(cyc == 3 + 3 + 2 + 2 + 2 + 2, "R12", "cycles with taken branch", cyc, 14);
   endtask

   task automatic t_flag_clear();
      int cyc;
      clear_mem();
      mem[0] = ins(C_LOAD, 'h100);
      mem[1] = ins(C_ADD, 'h101);
      mem[2] = ins(C_BRN, 'h10);
      mem[3] = ins(C_STORE, 'h120);
      mem[4] = ins(C_STOP, 0);
      mem['h10] = ins(C_STORE, 'h121);
      mem['h11] = ins(C_STOP, 0);
      mem['h100] = 16'hFFFF;
      mem['h101] = 16'h0002;
      mem['h121] = 16'hAAAA;
      do_reset('0);
      run(cyc);
      check(mem['h120] == 16'h0001, "R4", "negative plus two", int'(mem['h120]), 1);
      check(mem['h121] == 16'hAAAA, "R9", "flag cleared by add, branch not taken",
            int'(mem['h121]), 'hAAAA);
      check(cyc == 12, "R6", "not-taken branch path length", cyc, 12);
   endtask

   task automatic t_call_ret();
      int cyc;
      clear_mem();
      mem[0] = ins(C_CALL, 'h20);
      mem[1] = ins(C_STORE, 'h300);
      mem[2] = ins(C_STOP, 0);
      mem['h20] = ins(C_LOAD, 'h310);
      mem['h21] = ins(C_RET, 0);
      mem['h310] = 16'h0055;
      do_reset('0);
      run(cyc);
      check(mem['h300] == 16'h0055, "R8", "return resumes after call", int'(mem['h300]), 'h55);
      check(cyc == 11, "R7", "call/return path length", cyc, 11);
   endtask

   task automatic t_nested();
      int cyc;
      int b;
      int lg;
      clear_mem();
      b  = 'h80;
      lg = 'h380;
      mem[0] = ins(C_LOAD, 'h3F1);
      mem[1] = ins(C_CALL, b);
      mem[2] = ins(C_STORE, 'h3F2);
      mem[3] = ins(C_STOP, 0);
      for (int k = 0; k < 15; k++) begin
         mem[b + 4*k]     = ins(C_CALL, b + 4*(k+1));
         mem[b + 4*k + 1] = ins(C_STORE, lg + k);
         mem[b + 4*k + 2] = ins(C_ADD, 'h3F0);
         mem[b + 4*k + 3] = ins(C_RET, 0);
      end
      mem[b + 60] = ins(C_ADD, 'h3F0);
      mem[b + 61] = ins(C_RET, 0);
      mem['h3F0] = 16'd1;
      mem['h3F1] = 16'd0;
      do_reset('0);
      run(cyc);
      check(halted == 1'b1, "R7", "nested program halted", int'(halted), 1);
      check(mem['h3F2] == 16'd16, "R7", "sixteen-deep call count", int'(mem['h3F2]), 16);
      for (int k = 0; k < 15; k++) begin
         check(mem[lg + k] == 16'(15 - k), "R8", $sformatf("return order slot %0d", k),
               int'(mem[lg + k]), 15 - k);
      end
   endtask

   task automatic t_full_addr();
      int cyc;
      int w0;
      clear_mem();
      mem[0] = ins(C_LOAD, 'h50);
      mem[1] = ins(C_STORE, 'h1ABC);
      mem[2] = ins(C_STOP, 0);
      mem['h50] = 16'hBEEF;
      w0 = wr_cnt;
      do_reset('0);
      run(cyc);
      check(last_wa == 13'h1ABC, "R2", "full 13-bit store address", int'(last_wa), 'h1ABC);
      check(last_wd == 16'hBEEF, "R5", "store data", int'(last_wd), 'hBEEF);
      check(wr_cnt - w0 == 1, "R5", "one write cycle per store", wr_cnt - w0, 1);
   endtask

   task automatic t_spare_op();
      int cyc;
      clear_mem();
      mem[0] = ins(C_LOAD, 'h50);
      mem[1] = 16'hE000;
      mem[2] = ins(C_STORE, 'h60);
      mem[3] = ins(C_STOP, 0);
      mem['h50] = 16'h0007;
      do_reset('0);
      run(cyc);
      check(halted == 1'b1, "R11", "opcode 111 halts", int'(halted), 1);
      check(mem['h60] == 16'h0000, "R11", "no store after opcode 111", int'(mem['h60]), 0);
      check(cyc == 5, "R11", "cycles to halt on 111", cyc, 5);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      t_reset();
      t_load_add_store();
      t_wrap_taken();
      t_flag_clear();
      t_call_ret();
      t_nested();
      t_full_addr();
      t_spare_op();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule